// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment-relative address into a linear address. It holds six segment slots. Each slot keeps the selector value that was loaded into it and, next to it, a hidden cache of the base, limit and granularity taken from a segment descriptor. A translation request names a slot and a 32-bit offset. The result comes back one cycle later, either as a valid linear address or as a limit fault.

The `prot_mode` input chooses between two modes. In real mode a load only stores the 16-bit selector. A translation then returns the selector times 16 plus the low 16 bits of the offset, kept to 20 bits. In protected mode a load also fetches the 64-bit descriptor that belongs to the selector. The selector's table bit picks the global or the local table base, and the descriptor arrives as two 32-bit reads through a request/response memory port. While the fetch runs, `busy` is high and every new load or translation is dropped. A translation in protected mode adds the cached base to the offset and compares the offset with the effective limit, counted in bytes or in 4 KB units.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `busy`, `mem_req`, `lin_valid` and `lim_fault` are 0. Every slot holds selector 0, base 0, limit 0 and byte granularity.
- R2: In real mode a translation of slot s returns `lin_addr` = (selector × 16 + `xl_off[15:0]`) mod 2^20, with bits 31:20 at zero. `xl_off[31:16]` has no effect and no fault is raised.
- R3: A load in real mode writes only the selector of the slot in the cycle it is accepted. It starts no memory read, leaves `busy` low and leaves the cached base, limit and granularity unchanged.
- R4: A load in protected mode fetches the descriptor at (table base + selector[15:3] × 8). The table base is `ldt_base` when selector bit 2 is 1 and `gdt_base` when it is 0. The fetch issues two one-cycle `mem_req` pulses: the first at that address, and the second at that address + 4, issued after the first `mem_rvalid`.
- R5: `busy` is high from the cycle after an accepted protected load until the clock edge that takes the second `mem_rvalid`. While `busy` is high, loads and translations are ignored and give no output.
- R6: The first descriptor word is the 32-bit base. In the second word, bits 19:0 are the limit and bit 23 is the granularity (1 = 4 KB units). All other bits of the second word have no effect.
- R7: In protected mode a translation that does not fault returns `lin_addr` = (cached base + `xl_off`) mod 2^32.
- R8: The effective limit is the 20-bit limit for byte granularity, or {limit, 12'hFFF} for 4 KB granularity. An offset above the effective limit gives `lim_fault`=1 and `lin_valid`=0. An offset equal to it is valid. The two outputs are never high together.
- R9: A load that names slot 6 or 7 is ignored. A translation that names slot 6 or 7 returns `lim_fault` in either mode.
- R10: `lin_valid` or `lim_fault` is high for exactly the one cycle after an accepted translation request, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| gdt_base | input | 32 | Base address of the global descriptor table |
| ldt_base | input | 32 | Base address of the local descriptor table |
| ld_valid | input | 1 | Load a selector into a slot |
| ld_seg | input | 3 | Slot index for the load |
| ld_sel | input | 16 | Selector value to load |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | 3 | Slot index for the translation |
| xl_off | input | 32 | Offset to translate |
| mem_req | output | 1 | Descriptor read request (one-cycle pulse) |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Descriptor fetch in progress |
| lin_valid | output | 1 | Linear address valid |
| lin_addr | output | 32 | Linear address |
| lim_fault | output | 1 | Limit or slot fault |

## Verification
The assertions check on every cycle that results and faults never appear together, and that the outputs stay quiet when no request was accepted or while a fetch runs. They also check that real-mode results stay within 20 bits, that an offset past the limit or a bad slot always faults, and that read requests are single pulses inside a busy window. What only the bench scenarios can show is whether the numbers are right. That covers the descriptor address built from the selector index and table bit, the field positions in the fetched words, the 20-bit wrap in real mode, 32-bit wrap on the base add, the exact limit boundary in both granularities, and that a real-mode load keeps a slot's cached descriptor.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEL_W       = 16;
  localparam int ADDR_W      = 32;
  localparam int REAL_W      = 20;
  localparam int LIM_W       = 20;
  localparam int PAGE_SH     = 12;
  localparam int SEG_SH      = 4;
  localparam int TI_BIT      = 2;
  localparam int IDX_LSB     = 3;
  localparam int GRAN_BIT    = 23;
  localparam int DESC_HI_OFS = 4;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
  } seg_entry_t;

  // selector index scaled by the 8-byte descriptor size
  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] tbase,
                                                  input logic [SEL_W-1:0] sel);
    logic [SEL_W-1:0] scaled;
    scaled = {sel[SEL_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
    return tbase + ADDR_W'(scaled);
  endfunction

  function automatic logic [ADDR_W-1:0] real_linear(input logic [SEL_W-1:0] seg,
                                                    input logic [SEL_W-1:0] off);
    logic [REAL_W-1:0] sum;
    sum = {seg, {SEG_SH{1'b0}}} + REAL_W'(off);
    return ADDR_W'(sum);
  endfunction

  function automatic logic [ADDR_W-1:0] eff_limit(input logic [LIM_W-1:0] lim,
                                                  input logic gran);
    return gran ? {lim, {PAGE_SH{1'b1}}} : ADDR_W'(lim);
  endfunction

  function automatic seg_entry_t decode_desc(input logic [SEL_W-1:0]  sel,
                                             input logic [ADDR_W-1:0] lo_word,
                                             input logic [LIM_W-1:0]  lim,
                                             input logic              gran);
    seg_entry_t e;
    e.sel   = sel;
    e.base  = lo_word;
    e.limit = lim;
    e.gran  = gran;
    return e;
  endfunction

endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     start_seg,
  input  logic [SEL_W-1:0]  start_sel,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_en,
  output logic [IW-1:0]     wr_seg,
  output seg_entry_t        wr_entry
);

  typedef enum logic [2:0] {
    F_IDLE, F_REQ_LO, F_WAIT_LO, F_REQ_HI, F_WAIT_HI
  } fstate_t;

  fstate_t           state;
  logic [ADDR_W-1:0] tbl_addr;
  logic [IW-1:0]     p_seg;
  logic [SEL_W-1:0]  p_sel;
  logic [ADDR_W-1:0] lo_word;
  logic [ADDR_W-1:0] sel_tbase;
  logic              lo_capture;
  logic              unused_hi_bits;

  assign sel_tbase  = start_sel[TI_BIT] ? ldt_base : gdt_base;
  assign lo_capture = (state == F_WAIT_LO) && mem_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= F_IDLE;
      tbl_addr <= '0;
      p_seg    <= '0;
      p_sel    <= '0;
      lo_word  <= '0;
    end else begin
      case (state)
        F_IDLE: begin
          if (start) begin
            tbl_addr <= desc_addr(sel_tbase, start_sel);
            p_seg    <= start_seg;
            p_sel    <= start_sel;
            state    <= F_REQ_LO;
          end
        end
        F_REQ_LO:  state <= F_WAIT_LO;
        F_WAIT_LO: begin
          if (mem_rvalid) begin
            lo_word <= mem_rdata;
            state   <= F_REQ_HI;
          end
        end
        F_REQ_HI:  state <= F_WAIT_HI;
        F_WAIT_HI: if (mem_rvalid) state <= F_IDLE;
        default:   state <= F_IDLE;
      endcase
    end
  end

  assign busy     = (state != F_IDLE);
  assign mem_req  = (state == F_REQ_LO) || (state == F_REQ_HI);
  assign mem_addr = tbl_addr + ((state == F_REQ_HI) ? ADDR_W'(DESC_HI_OFS) : '0);
  assign wr_en    = (state == F_WAIT_HI) && mem_rvalid;
  assign wr_seg   = p_seg;
  assign wr_entry = decode_desc(p_sel, lo_word, mem_rdata[LIM_W-1:0], mem_rdata[GRAN_BIT]);
  assign unused_hi_bits = ^{mem_rdata[ADDR_W-1:GRAN_BIT+1], mem_rdata[GRAN_BIT-1:LIM_W]};

  // R4: every read request lies inside a busy window
  assert_req_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  // R4: requests are single-cycle pulses
  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R4: the low word is taken before the second request appears
  assert_lo_then_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_capture |=> mem_req);
  // R5: taking the second word ends the busy window
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !busy);
  // R5: a new start is only seen while idle
  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IW      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_we,
  input  logic [IW-1:0]    desc_seg,
  input  seg_entry_t       desc_entry,
  input  logic             real_we,
  input  logic [IW-1:0]    real_seg,
  input  logic [SEL_W-1:0] real_sel,
  input  logic [IW-1:0]    rd_seg,
  output logic             rd_hit,
  output seg_entry_t       rd_entry
);

  localparam logic [IW:0] SEG_LIM = (IW+1)'(NUM_SEG);

  seg_entry_t slot [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (desc_we && (desc_seg == IW'(g))) begin
        slot[g] <= desc_entry;
      end else if (real_we && (real_seg == IW'(g))) begin
        slot[g].sel <= real_sel;
      end
    end
  end

  always_comb begin
    rd_hit   = ({1'b0, rd_seg} < SEG_LIM);
    rd_entry = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_seg == IW'(i)) rd_entry = slot[i];
    end
  end

  // R5: the two write paths never collide because real loads need an idle unit
  assert_one_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_we && real_we));

endmodule

// File: rtl/seg_xlate_core.sv
module seg_xlate_core
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              prot,
  input  logic              hit,
  input  seg_entry_t        entry,
  input  logic [ADDR_W-1:0] off,
  output logic              lin_valid,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              lim_fault
);

  logic [ADDR_W-1:0] lim_eff;
  logic              over_limit;
  logic [ADDR_W-1:0] prot_sum;
  logic [ADDR_W-1:0] real_sum;
  logic              fault_now;

  assign lim_eff    = eff_limit(entry.limit, entry.gran);
  assign over_limit = off > lim_eff;
  assign prot_sum   = entry.base + off;
  assign real_sum   = real_linear(entry.sel, off[SEL_W-1:0]);
  assign fault_now  = !hit || (prot && over_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_valid <= 1'b0;
      lim_fault <= 1'b0;
      lin_addr  <= '0;
    end else begin
      lin_valid <= req && !fault_now;
      lim_fault <= req && fault_now;
      if (req && !fault_now) lin_addr <= prot ? prot_sum : real_sum;
    end
  end

  // R8: result and fault are exclusive
  assert_excl_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lin_valid && lim_fault));
  // R8: an offset past the effective limit faults
  assert_over_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && prot && hit && over_limit) |=> (lim_fault && !lin_valid));
  // R2: real-mode results fit in 20 bits and never fault
  assert_real_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !prot && hit) |=> (lin_valid && (lin_addr[ADDR_W-1:REAL_W] == '0)));
  // R9: a slot index past the last slot faults
  assert_bad_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hit) |=> lim_fault);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IW      = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prot_mode,
  input  logic [31:0] gdt_base,
  input  logic [31:0] ldt_base,
  input  logic        ld_valid,
  input  logic [2:0]  ld_seg,
  input  logic [15:0] ld_sel,
  input  logic        xl_valid,
  input  logic [2:0]  xl_seg,
  input  logic [31:0] xl_off,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        busy,
  output logic        lin_valid,
  output logic [31:0] lin_addr,
  output logic        lim_fault
);

  localparam logic [IW:0] SEG_LIM = (IW+1)'(NUM_SEG);

  logic       ld_in_range;
  logic       ld_accept;
  logic       fetch_start;
  logic       real_load;
  logic       xl_accept;
  logic       desc_we;
  logic [IW-1:0] desc_seg;
  seg_entry_t desc_entry;
  logic       rd_hit;
  seg_entry_t rd_entry;

  assign ld_in_range = ({1'b0, ld_seg} < SEG_LIM);
  assign ld_accept   = ld_valid && !busy && ld_in_range;
  assign fetch_start = ld_accept && prot_mode;
  assign real_load   = ld_accept && !prot_mode;
  assign xl_accept   = xl_valid && !busy;

  seg_desc_fetch #(.IW(IW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fetch_start),
    .start_seg  (ld_seg),
    .start_sel  (ld_sel),
    .gdt_base   (gdt_base),
    .ldt_base   (ldt_base),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .wr_en      (desc_we),
    .wr_seg     (desc_seg),
    .wr_entry   (desc_entry)
  );

  seg_reg_bank #(.NUM_SEG(NUM_SEG), .IW(IW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_we    (desc_we),
    .desc_seg   (desc_seg),
    .desc_entry (desc_entry),
    .real_we    (real_load),
    .real_seg   (ld_seg),
    .real_sel   (ld_sel),
    .rd_seg     (xl_seg),
    .rd_hit     (rd_hit),
    .rd_entry   (rd_entry)
  );

  seg_xlate_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (xl_accept),
    .prot      (prot_mode),
    .hit       (rd_hit),
    .entry     (rd_entry),
    .off       (xl_off),
    .lin_valid (lin_valid),
    .lin_addr  (lin_addr),
    .lim_fault (lim_fault)
  );

  // R5: requests seen while busy produce nothing
  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && busy) |=> (!lin_valid && !lim_fault));
  // R3: a real-mode load never starts a fetch
  assert_real_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !prot_mode && !busy) |=> !busy);
  // R5: an accepted protected load raises busy
  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> busy);
  // R10: no request, no output
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |=> (!lin_valid && !lim_fault));

endmodule

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;

  localparam time CLK_PERIOD = 10ns;
  localparam int  MEM_LAT    = 2;
  localparam int  WDOG_MAX   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_mode = 1'b0;
  logic [31:0] gdt_base = 32'h0000_1000;
  logic [31:0] ldt_base = 32'h0000_8000;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic        xl_valid = 1'b0;
  logic [2:0]  xl_seg = '0;
  logic [31:0] xl_off = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, lin_valid, lim_fault;
  logic [31:0] lin_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit cmp_on   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .gdt_base(gdt_base), .ldt_base(ldt_base),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .xl_valid(xl_valid), .xl_seg(xl_seg),
    .xl_off(xl_off), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .lin_valid(lin_valid), .lin_addr(lin_addr),
    .lim_fault(lim_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // descriptor memory
  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return (a * 32'h0001_0DCB) ^ 32'h3C5A_0F11;
  endfunction

  int          pend = 0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pend <= 0; mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      if (pend == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_word(pend_addr);
      end
      if (pend > 0) pend <= pend - 1;
      if (mem_req === 1'b1) begin
        pend      <= MEM_LAT;
        pend_addr <= mem_addr;
      end
    end
  end

  // behavioural reference model
  logic [15:0] m_sel  [6];
  logic [31:0] m_base [6];
  logic [19:0] m_lim  [6];
  logic        m_gran [6];
  int          m_phase = 0;
  logic [31:0] m_daddr = '0;
  logic [2:0]  m_pseg = '0;
  logic [15:0] m_psel = '0;
  logic [31:0] m_lo = '0;
  logic        m_lv = 0, m_lf = 0;
  logic [31:0] m_la = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin
        m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '0; m_gran[i] = 1'b0;
      end
      m_phase = 0; m_lv = 0; m_lf = 0; m_la = '0;
    end else begin
      int ph;
      ph = m_phase;
      m_lv = 0; m_lf = 0;
      if (xl_valid && ph == 0) begin
        if (xl_seg > 3'd5) m_lf = 1;
        else if (prot_mode) begin
          longint lim;
          lim = m_gran[xl_seg] ? (longint'(m_lim[xl_seg]) * 4096 + 4095) : longint'(m_lim[xl_seg]);
          if (longint'(xl_off) > lim) m_lf = 1;
          else begin m_lv = 1; m_la = m_base[xl_seg] + xl_off; end
        end else begin
          int s;
          s = (int'(m_sel[xl_seg]) * 16 + int'(xl_off & 32'hFFFF)) % (1 << 20);
          m_lv = 1; m_la = 32'(s);
        end
      end
      if (ph == 0) begin
        if (ld_valid && ld_seg <= 3'd5) begin
          if (!prot_mode) m_sel[ld_seg] = ld_sel;
          else begin
            m_phase = 1; m_pseg = ld_seg; m_psel = ld_sel;
            m_daddr = (ld_sel[2] ? ldt_base : gdt_base) + 32'(ld_sel >> 3) * 8;
          end
        end
      end else if (ph == 1) m_phase = 2;
      else if (ph == 2) begin
        if (mem_rvalid) begin m_lo = mem_rdata; m_phase = 3; end
      end else if (ph == 3) m_phase = 4;
      else if (ph == 4 && mem_rvalid) begin
        m_sel[m_pseg] = m_psel; m_base[m_pseg] = m_lo;
        m_lim[m_pseg] = mem_rdata[19:0]; m_gran[m_pseg] = mem_rdata[23];
        m_phase = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R5 busy", 32'(busy), 32'(m_phase != 0));
      chk("R4 mem_req", 32'(mem_req), 32'(m_phase == 1 || m_phase == 3));
      if (m_phase == 1) chk("R4 mem_addr lo", mem_addr, m_daddr);
      if (m_phase == 3) chk("R4 mem_addr hi", mem_addr, m_daddr + 32'd4);
      chk("R10 lin_valid", 32'(lin_valid), 32'(m_lv));
      chk("R8 lim_fault", 32'(lim_fault), 32'(m_lf));
      if (m_lv) chk("R7/R2 lin_addr", lin_addr, m_la);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_MAX && !done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG_MAX);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_load(input logic pm, input logic [2:0] s, input logic [15:0] sel);
    prot_mode = pm; ld_valid = 1; ld_seg = s; ld_sel = sel;
    @(negedge clk);
    ld_valid = 0;
    wait_idle();
  endtask

  task automatic do_xl(input logic pm, input logic [2:0] s, input logic [31:0] off,
                       output logic v, output logic [31:0] a, output logic f);
    prot_mode = pm; xl_valid = 1; xl_seg = s; xl_off = off;
    @(negedge clk);
    xl_valid = 0;
    v = lin_valid; a = lin_addr; f = lim_fault;
  endtask

  initial begin
    logic v, f;
    logic [31:0] a;
    mem[32'h0000_1028] = 32'h0040_0000;
    mem[32'h0000_102C] = 32'h0070_0100;
    mem[32'h0000_8010] = 32'hFFFF_F000;
    mem[32'h0000_8014] = 32'hFF80_0001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 lin_valid", 32'(lin_valid), 0);
    chk("R1 lim_fault", 32'(lim_fault), 0);
    do_xl(1, 3'd0, 32'h0, v, a, f);
    chk("R1 empty slot valid", 32'(v), 1);
    chk("R1 empty slot addr", a, 32'h0);
    do_xl(1, 3'd0, 32'h1, v, a, f);
    chk("R1 empty slot limit", 32'(f), 1);
    @(negedge clk);
    chk("R10 pulse ends", 32'(lin_valid | lim_fault), 0);

    // R2/R3 real mode
    do_load(0, 3'd1, 16'hA1F0);
    chk("R3 no busy", 32'(busy), 0);
    do_xl(0, 3'd1, 32'h0000_04C0, v, a, f);
    chk("R2 real sum", a, 32'h000A_23C0);
    do_xl(0, 3'd1, 32'hDEAD_04C0, v, a, f);
    chk("R2 upper offset ignored", a, 32'h000A_23C0);
    chk("R2 no fault", 32'(f), 0);
    do_load(0, 3'd2, 16'hFFFF);
    do_xl(0, 3'd2, 32'h0000_FFFF, v, a, f);
    chk("R2 20-bit wrap", a, 32'h0000_FFEF);

    // R4/R6/R7/R8 protected mode
    do_load(1, 3'd3, 16'h002B);
    do_xl(1, 3'd3, 32'h100, v, a, f);
    chk("R8 byte limit edge valid", 32'(v), 1);
    chk("R7 base add", a, 32'h0040_0100);
    do_xl(1, 3'd3, 32'h101, v, a, f);
    chk("R8 byte limit exceeded", {30'h0, v, f}, 32'h1);
    do_load(1, 3'd4, 16'h0014);
    do_xl(1, 3'd4, 32'h1FFF, v, a, f);
    chk("R6 page granularity valid", 32'(v), 1);
    chk("R7 32-bit wrap", a, 32'h0000_0FFF);
    do_xl(1, 3'd4, 32'h2000, v, a, f);
    chk("R8 page limit exceeded", {30'h0, v, f}, 32'h1);

    // R3 real load keeps cached descriptor
    do_load(0, 3'd3, 16'h0000);
    do_xl(1, 3'd3, 32'h100, v, a, f);
    chk("R3 cache kept", a, 32'h0040_0100);

    // R5 requests during busy ignored
    prot_mode = 1; ld_valid = 1; ld_seg = 3'd5; ld_sel = 16'h002B;
    @(negedge clk);
    ld_valid = 0;
    chk("R5 busy raised", 32'(busy), 1);
    xl_valid = 1; xl_seg = 3'd3; xl_off = 32'h0;
    prot_mode = 0; ld_valid = 1; ld_seg = 3'd1; ld_sel = 16'h1234;
    @(negedge clk);
    xl_valid = 0; ld_valid = 0;
    chk("R5 no output while busy", 32'(lin_valid | lim_fault), 0);
    wait_idle();
    do_xl(0, 3'd1, 32'h0, v, a, f);
    chk("R5 load during busy ignored", a, 32'h000A_1F00);
    do_xl(1, 3'd5, 32'h80, v, a, f);
    chk("R4 fetched descriptor", a, 32'h0040_0080);

    // R9 slots past the last
    do_load(0, 3'd6, 16'h1111);
    do_xl(0, 3'd6, 32'h0, v, a, f);
    chk("R9 bad slot real", 32'(f), 1);
    do_xl(1, 3'd7, 32'h0, v, a, f);
    chk("R9 bad slot prot", 32'(f), 1);

    // random traffic, compared each cycle by the model
    for (int k = 0; k < 600; k++) begin
      prot_mode = $urandom_range(0, 3) != 0;
      ld_valid  = $urandom_range(0, 5) == 0;
      ld_seg    = 3'($urandom_range(0, 7));
      ld_sel    = 16'($urandom);
      xl_valid  = $urandom_range(0, 1) == 1;
      xl_seg    = 3'($urandom_range(0, 7));
      xl_off    = ($urandom_range(0, 1) == 1) ? $urandom : 32'($urandom_range(0, 20'hFFFFF));
      @(negedge clk);
    end
    ld_valid = 0; xl_valid = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule